// File: doc/BRIEF.md
# Static Memory Chip-Select Timing Engine

This block turns single host requests into correctly timed cycles on an external asynchronous static memory bus with eight chip selects. Each chip select has its own 32-bit timing word, supplied as a parallel input. The word sets how long the address is valid around the chip-select window, how long the chip select leads and trails the strobe, and how long the strobe lasts. It also sets whether a read strobe waits for the setup interval, how many idle cycles follow a read before another access may drive the bus, and how the 16 data lines are used.

The host presents a request with a chip-select index, a byte address, write data, byte enables and a write flag. It holds the request until a one-cycle ready pulse, which also carries read data. Each access runs through a fixed sequence: address setup, chip-select setup, strobe active, chip-select hold, address hold. A phase programmed to zero cycles is skipped. Outside an access the address bus is driven to zero and every strobe and chip select is high.

Top module: `smc_cs_engine`

## Requirements
- R1: While reset is held low at a clock edge, all chip selects, the read strobe and both write strobes are high, ready is low, the data output enable is low and the address output is zero.
- R2: Timing word i occupies bits [32*i+31:32*i] of the configuration input. An access to chip select i uses that word and drives only mem_cs_n[i] low.
- R3: Bits 17:16 of the word give A (0 to 3). The nonzero address is driven for exactly A cycles before the chip select falls and for exactly A cycles after it rises, and it is zero outside the access.
- R4: Bits 25:24 give the number of cycles the chip select is low before the strobe falls. Bits 29:28 give the number of cycles it stays low after the strobe rises. Strobes are only low while a chip select is low.
- R5: When bit 7 is set the strobe is low for bits 6:0 plus one cycles. When bit 7 is clear the strobe lasts one cycle whatever bits 6:0 hold.
- R6: When bit 15 is set, a read strobe falls in the same cycle as the chip select and the setup count is skipped. Writes always use the setup count. When bit 15 is clear, reads also use it.
- R7: Ready is high for exactly one cycle, 2A+S+W+H+1 cycles after the request is first presented to an idle engine, where S, W and H are the setup, strobe and hold lengths. Read data is the bus value sampled in the last strobe cycle.
- R8: After a read, bits 11:8 of that read's word give G. A following write, or an access to another chip select, presented right after ready is delayed by exactly G cycles. A read of the same chip select is not delayed.
- R9: When bits 14:13 equal 2 the bus is 8 bits wide: the address is the byte address, only mem_wr_n[0] strobes on writes, only data bits 7:0 are written and read, and read bits 15:8 are zero. Any other value gives a 16-bit bus with the address equal to the byte address shifted right by one.
- R10: On a 16-bit bus with bit 12 set, mem_wr_n[k] strobes only when byte enable k is set. With bit 12 clear, both write strobes fall together whatever the byte enables are.
- R11: During a write the data output enable is high and the write data is on the bus throughout the strobe. During a read the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_words | input | NUM_CS*32 | Timing words, one per chip select |
| req_valid | input | 1 | Host request, held until ready |
| req_cs | input | CS_W | Target chip-select index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | LANES | Byte enables |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Read data, valid with ready |
| mem_addr | output | ADDR_W | Device address |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | LANES | Per-byte write strobes, active low |
| mem_dq_out | output | DATA_W | Data driven to the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | DATA_W | Data returned by the bus |

## Verification
The bench measures every phase of every access on the device pins, so an engine that miscounts a setup, hold or guard interval by one cycle, or skips a zero-length phase incorrectly, shows a wrong length. A device model returns a value that changes every strobe cycle. An engine that captures read data early therefore returns a stale value. Reads with the enable bit clear but a large wait field, and a 128-cycle strobe, catch a strobe length taken from the wrong bits. Float-gap cases mix same-select reads, cross-select accesses and writes after reads, so a gap applied too widely or not at all changes the ready latency. Early-read selects, 8-bit selects and dual-byte selects with each byte-enable pattern expose a strobe that waits for setup, a shifted address, or a wrong lane.

// File: rtl/smc_pkg.sv
// Shared types and helpers for the static memory timing engine.
// Assumes a 32-bit timing word per chip select.
package smc_pkg;

    // Decoded per-select timing word
    typedef struct packed {
        logic [1:0] cs_hold;
        logic [1:0] cs_setup;
        logic [1:0] addr_guard;
        logic       early_rd;
        logic [1:0] bus_width;
        logic       dual_byte;
        logic [3:0] float_gap;
        logic       wait_en;
        logic [6:0] wait_cnt;
    } cs_timing_t;

    // Access phases, in the order they occur
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR_SU,
        PH_CS_SU,
        PH_STROBE,
        PH_CS_HOLD,
        PH_ADDR_HOLD,
        PH_DONE
    } phase_t;

    localparam logic [1:0] WIDTH_8 = 2'd2;

    // Split a raw timing word into its fields
    function automatic cs_timing_t decode_word(input logic [31:0] w);
        cs_timing_t t;
        t.cs_hold    = w[29:28];
        t.cs_setup   = w[25:24];
        t.addr_guard = w[17:16];
        t.early_rd   = w[15];
        t.bus_width  = w[14:13];
        t.dual_byte  = w[12];
        t.float_gap  = w[11:8];
        t.wait_en    = w[7];
        t.wait_cnt   = w[6:0];
        return t;
    endfunction

    // Number of cycles a phase lasts for a given word and direction
    function automatic logic [7:0] phase_len(input phase_t p, input cs_timing_t t,
                                             input logic wr);
        logic [7:0] n;
        case (p)
            PH_ADDR_SU, PH_ADDR_HOLD: n = {6'd0, t.addr_guard};
            PH_CS_SU:   n = (!wr && t.early_rd) ? 8'd0 : {6'd0, t.cs_setup};
            PH_STROBE:  n = t.wait_en ? ({1'b0, t.wait_cnt} + 8'd1) : 8'd1;
            PH_CS_HOLD: n = {6'd0, t.cs_hold};
            default:    n = 8'd1;
        endcase
        return n;
    endfunction

    // Next non-empty phase after p
    function automatic phase_t phase_after(input phase_t p, input cs_timing_t t,
                                           input logic wr);
        logic   su;
        logic   ag;
        logic   hd;
        phase_t r;
        su = (phase_len(PH_CS_SU, t, wr) != 8'd0);
        ag = (t.addr_guard != 2'd0);
        hd = (t.cs_hold != 2'd0);
        case (p)
            PH_IDLE:      r = ag ? PH_ADDR_SU : (su ? PH_CS_SU : PH_STROBE);
            PH_ADDR_SU:   r = su ? PH_CS_SU : PH_STROBE;
            PH_CS_SU:     r = PH_STROBE;
            PH_STROBE:    r = hd ? PH_CS_HOLD : (ag ? PH_ADDR_HOLD : PH_DONE);
            PH_CS_HOLD:   r = ag ? PH_ADDR_HOLD : PH_DONE;
            PH_ADDR_HOLD: r = PH_DONE;
            default:      r = PH_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/smc_cfg_select.sv
// Picks the timing word of one chip select out of the flat configuration
// bus and decodes it. Assumes sel < NUM_CS.
module smc_cfg_select
    import smc_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int CFG_W  = 32,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [NUM_CS*CFG_W-1:0] cfg_words,
    input  logic [CS_W-1:0]         sel,
    output cs_timing_t              timing
);

    logic [CFG_W-1:0] word_arr [NUM_CS];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
        assign word_arr[g] = cfg_words[g*CFG_W +: CFG_W];
    end

    // Decode the selected word
    always_comb timing = decode_word(word_arr[sel]);

endmodule

// File: rtl/smc_phase_seq.sv
// Steps one access through its phases, skipping empty ones, and counts
// cycles within each phase. Assumes timing and wr are the live request
// values in idle and the captured values afterwards.
module smc_phase_seq
    import smc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  cs_timing_t timing,
    input  logic       wr,
    output phase_t     phase,
    output logic       last_beat
);

    logic [7:0] cnt;
    phase_t     nxt_ph;
    logic       adv;

    // Decide whether to move on, and where to
    always_comb begin
        adv    = (phase == PH_IDLE) ? start : (cnt == 8'd0);
        nxt_ph = phase_after(phase, timing, wr);
    end

    assign last_beat = (cnt == 8'd0);

    // Phase register and in-phase cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= 8'd0;
        end else if (adv) begin
            phase <= nxt_ph;
            cnt   <= phase_len(nxt_ph, timing, wr) - 8'd1;
        end else begin
            cnt   <= cnt - 8'd1;
        end
    end

    // R4
    hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CS_HOLD) |-> ($past(phase) inside {PH_STROBE, PH_CS_HOLD}));

endmodule

// File: rtl/smc_float_guard.sv
// Counts the bus float time after a read and holds off any following
// access that would drive the bus (a write or another chip select).
module smc_float_guard
    import smc_pkg::*;
#(
    parameter int CS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_t          phase,
    input  logic            we_lat,
    input  logic [CS_W-1:0] cs_lat,
    input  logic [3:0]      gap_lat,
    input  logic            req_write,
    input  logic [CS_W-1:0] req_cs,
    input  logic            start,
    output logic            block
);

    logic [3:0]      gap_cnt;
    logic [CS_W-1:0] last_cs;

    // Load the gap at the end of a read, then count down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= 4'd0;
            last_cs <= '0;
        end else if (phase == PH_DONE && !we_lat) begin
            gap_cnt <= gap_lat;
            last_cs <= cs_lat;
        end else if (gap_cnt != 4'd0) begin
            gap_cnt <= gap_cnt - 4'd1;
        end
    end

    // Hold off accesses that would fight a floating bus
    always_comb block = (gap_cnt != 4'd0) && (req_write || (req_cs != last_cs));

    // R8
    gap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req_write) |-> (gap_cnt == 4'd0));

endmodule

// File: rtl/smc_pin_drive.sv
// Forms the device-side address, chip selects, strobes and data bus from
// the current phase and the captured request; captures read data in the
// last strobe cycle. Assumes DATA_W is a multiple of 8 and at least 16.
module smc_pin_drive
    import smc_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              last_beat,
    input  logic [CS_W-1:0]   cs_lat,
    input  logic [ADDR_W-1:0] addr_lat,
    input  logic [DATA_W-1:0] wdata_lat,
    input  logic [LANES-1:0]  be_lat,
    input  logic              we_lat,
    input  cs_timing_t        tim_lat,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_rd_n,
    output logic [LANES-1:0]  mem_wr_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata
);

    logic is8;
    logic cs_win;
    logic in_access;
    logic strobe;

    // Phase-derived window flags
    always_comb begin
        is8       = (tim_lat.bus_width == WIDTH_8);
        cs_win    = phase inside {PH_CS_SU, PH_STROBE, PH_CS_HOLD};
        in_access = phase inside {PH_ADDR_SU, PH_CS_SU, PH_STROBE, PH_CS_HOLD, PH_ADDR_HOLD};
        strobe    = (phase == PH_STROBE);
    end

    // Address: byte address on an 8-bit bus, halfword address otherwise
    always_comb begin
        if (!in_access)
            mem_addr = '0;
        else if (is8)
            mem_addr = addr_lat;
        else
            mem_addr = addr_lat >> 1;
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign mem_cs_n[g] = !(cs_win && (cs_lat == CS_W'(g)));
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic lane_en;
        // Which byte lanes strobe on a write
        always_comb begin
            if (is8)
                lane_en = (l == 0);
            else if (tim_lat.dual_byte)
                lane_en = be_lat[l];
            else
                lane_en = 1'b1;
        end
        assign mem_wr_n[l] = !(strobe && we_lat && lane_en);
    end

    // Read strobe, data drive and ready
    always_comb begin
        mem_rd_n   = !(strobe && !we_lat);
        mem_dq_oe  = cs_win && we_lat;
        mem_dq_out = is8 ? {{(DATA_W-8){1'b0}}, wdata_lat[7:0]} : wdata_lat;
        req_ready  = (phase == PH_DONE);
    end

    // Capture read data on the final strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_rdata <= '0;
        else if (strobe && last_beat && !we_lat)
            req_rdata <= is8 ? {{(DATA_W-8){1'b0}}, mem_dq_in[7:0]} : mem_dq_in;
    end

    // R6
    early_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_rd_n) && tim_lat.early_rd) |-> $past(&mem_cs_n));

    // R11
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_n != '1) |-> (mem_dq_oe && mem_rd_n));

endmodule

// File: rtl/smc_cs_engine.sv
// Top of the static memory chip-select timing engine. Accepts one host
// request at a time, captures it with its chip select's timing word and
// runs it on the device pins. Assumes the host holds a request until ready.
module smc_cs_engine
    import smc_pkg::*;
#(
    parameter int NUM_CS = 8,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int CFG_W  = 32,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int LANES = DATA_W / 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CS*CFG_W-1:0] cfg_words,
    input  logic                    req_valid,
    input  logic [CS_W-1:0]         req_cs,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    input  logic [LANES-1:0]        req_be,
    output logic                    req_ready,
    output logic [DATA_W-1:0]       req_rdata,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [NUM_CS-1:0]       mem_cs_n,
    output logic                    mem_rd_n,
    output logic [LANES-1:0]        mem_wr_n,
    output logic [DATA_W-1:0]       mem_dq_out,
    output logic                    mem_dq_oe,
    input  logic [DATA_W-1:0]       mem_dq_in
);

    cs_timing_t        tim_live;
    cs_timing_t        tim_lat;
    cs_timing_t        tim_use;
    logic              we_use;
    logic [CS_W-1:0]   cs_lat;
    logic [ADDR_W-1:0] addr_lat;
    logic [DATA_W-1:0] wdata_lat;
    logic [LANES-1:0]  be_lat;
    logic              we_lat;
    phase_t            phase;
    logic              last_beat;
    logic              block;
    logic              start;

    smc_cfg_select #(.NUM_CS(NUM_CS), .CFG_W(CFG_W)) u_sel (
        .cfg_words (cfg_words),
        .sel       (req_cs),
        .timing    (tim_live)
    );

    // Accept a request when idle and not held off by the float gap
    always_comb begin
        start   = req_valid && (phase == PH_IDLE) && !block;
        tim_use = (phase == PH_IDLE) ? tim_live : tim_lat;
        we_use  = (phase == PH_IDLE) ? req_write : we_lat;
    end

    // Capture the request and its timing at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_lat   <= '0;
            cs_lat    <= '0;
            addr_lat  <= '0;
            wdata_lat <= '0;
            be_lat    <= '0;
            we_lat    <= 1'b0;
        end else if (start) begin
            tim_lat   <= tim_live;
            cs_lat    <= req_cs;
            addr_lat  <= req_addr;
            wdata_lat <= req_wdata;
            be_lat    <= req_be;
            we_lat    <= req_write;
        end
    end

    smc_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .timing    (tim_use),
        .wr        (we_use),
        .phase     (phase),
        .last_beat (last_beat)
    );

    smc_float_guard #(.CS_W(CS_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .we_lat    (we_lat),
        .cs_lat    (cs_lat),
        .gap_lat   (tim_lat.float_gap),
        .req_write (req_write),
        .req_cs    (req_cs),
        .start     (start),
        .block     (block)
    );

    smc_pin_drive #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .last_beat  (last_beat),
        .cs_lat     (cs_lat),
        .addr_lat   (addr_lat),
        .wdata_lat  (wdata_lat),
        .be_lat     (be_lat),
        .we_lat     (we_lat),
        .tim_lat    (tim_lat),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_rd_n   (mem_rd_n),
        .mem_wr_n   (mem_wr_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .req_ready  (req_ready),
        .req_rdata  (req_rdata)
    );

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R4
    strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || (mem_wr_n != '1)) |-> (mem_cs_n != '1));

    // R3
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_cs_n != '1) && $past(mem_cs_n != '1)) |-> $stable(mem_addr));

    // R2
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1);

endmodule

// File: tb/sim_smc_cs_engine.sv
// Scoreboard bench: the driver task queues the expected pin-level shape of
// each access; a monitor measures the pins and compares on completion.
module sim_smc_cs_engine;

    localparam int NCS = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [255:0]    cfg_words;
    logic            req_valid = 1'b0;
    logic [2:0]      req_cs = '0;
    logic            req_write = 1'b0;
    logic [23:0]     req_addr = '0;
    logic [15:0]     req_wdata = '0;
    logic [1:0]      req_be = '0;
    logic            req_ready;
    logic [15:0]     req_rdata;
    logic [23:0]     mem_addr;
    logic [7:0]      mem_cs_n;
    logic            mem_rd_n;
    logic [1:0]      mem_wr_n;
    logic [15:0]     mem_dq_out;
    logic            mem_dq_oe;
    logic [15:0]     mem_dq_in = 16'hDEAD;

    logic [31:0] cfgw [NCS];
    int checks = 0;
    int fails  = 0;
    logic [15:0] rd_pat = '0;

    typedef struct {
        int         cs;
        bit         we;
        int         ag;
        int         su;
        int         st;
        int         hd;
        logic [1:0] lanes;
        logic [23:0] addr;
        logic [15:0] wdata;
        logic [15:0] mask;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    always_comb for (int i = 0; i < NCS; i++) cfg_words[i*32 +: 32] = cfgw[i];

    smc_cs_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_words(cfg_words),
        .req_valid(req_valid), .req_cs(req_cs), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] mk(int hold, int setup, int ag, bit early, int width,
                                       bit dual, int gap, bit wen, int ws);
        logic [31:0] w = '0;
        w[29:28] = 2'(hold);  w[25:24] = 2'(setup); w[17:16] = 2'(ag);
        w[15] = early; w[14:13] = 2'(width); w[12] = dual;
        w[11:8] = 4'(gap); w[7] = wen; w[6:0] = 7'(ws);
        return w;
    endfunction

    // Device model: returns a value that changes every read strobe cycle
    int rd_k = 0;
    always @(negedge clk) begin
        if (!mem_rd_n) begin
            mem_dq_in <= rd_pat + 16'(rd_k);
            rd_k++;
        end else begin
            rd_k = 0;
            mem_dq_in <= 16'hDEAD;
        end
    end

    // Monitor: measure each access at the pins and compare with the queue
    int mst = 0, pre_a = 0, post_a = 0, c_su = 0, c_st = 0, c_hd = 0, m_cs = 0;
    bit seen = 0, m_rd = 0, m_oe = 0;
    logic [1:0] m_lanes;
    logic [15:0] m_dq;
    always @(negedge clk) begin
        if (rst_n) begin
            bit cs_low;
            bit fin;
            cs_low = (mem_cs_n != 8'hFF);
            fin = 0;
            if (mst == 0) begin
                if (!cs_low) pre_a = (mem_addr != 0) ? pre_a + 1 : 0;
                else begin
                    mst = 1; c_su = 0; c_st = 0; c_hd = 0; seen = 0;
                    m_cs = -1;
                    for (int i = 0; i < NCS; i++) if (!mem_cs_n[i]) m_cs = i;
                    if ($countones(~mem_cs_n) != 1) m_cs = -2;
                end
            end
            if (mst == 1) begin
                if (cs_low) begin
                    if (!mem_rd_n || mem_wr_n != 2'b11) begin
                        if (!seen) begin
                            m_lanes = ~mem_wr_n; m_rd = !mem_rd_n;
                            m_oe = mem_dq_oe; m_dq = mem_dq_out;
                        end
                        seen = 1; c_st++;
                    end else if (!seen) c_su++;
                    else c_hd++;
                end else begin
                    mst = 2; post_a = 0;
                end
            end
            if (mst == 2) begin
                if (mem_addr != 0) post_a++;
                else fin = 1;
            end
            if (fin) begin
                exp_t e;
                mst = 0;
                if (exp_q.size() == 0) chk(0, "R2 unexpected access", m_cs, -1);
                else begin
                    e = exp_q.pop_front();
                    chk(m_cs == e.cs, "R2 chip select", m_cs, e.cs);
                    chk(pre_a == e.ag, "R3 address setup", pre_a, e.ag);
                    chk(post_a == e.ag, "R3 address hold", post_a, e.ag);
                    chk(c_su == e.su, "R4/R6 cs setup", c_su, e.su);
                    chk(c_hd == e.hd, "R4 cs hold", c_hd, e.hd);
                    chk(c_st == e.st, "R5 strobe width", c_st, e.st);
                    chk(m_lanes == e.lanes, "R9/R10 write lanes", m_lanes, e.lanes);
                    chk(m_rd == !e.we, "R11 read strobe", m_rd, !e.we);
                    chk(m_oe == e.we, "R11 bus enable", m_oe, e.we);
                    if (e.we) chk((m_dq & e.mask) == (e.wdata & e.mask), "R11 write data",
                                  m_dq & e.mask, e.wdata & e.mask);
                end
                pre_a = 0;
            end
            if (mst == 2 && fin == 0 && mem_addr != 0) ;
        end
    end

    // Address value at strobe, checked by the driver via the monitor's window
    bit last_rd = 0;
    int last_cs = 0, last_gap = 0;

    task automatic do_acc(input int cs, input bit we, input logic [23:0] addr,
                          input logic [15:0] wd, input logic [1:0] be, input string tag);
        logic [31:0] w;
        exp_t e;
        int gap, lat, want;
        bit w8;
        logic [15:0] exp_rd;
        w = cfgw[cs];
        w8 = (w[14:13] == 2'd2);
        e.cs = cs; e.we = we; e.ag = int'(w[17:16]);
        e.su = (!we && w[15]) ? 0 : int'(w[25:24]);
        e.st = w[7] ? int'(w[6:0]) + 1 : 1;
        e.hd = int'(w[29:28]);
        e.lanes = we ? (w8 ? 2'b01 : (w[12] ? be : 2'b11)) : 2'b00;
        e.addr = w8 ? addr : addr >> 1;
        e.wdata = wd;
        e.mask = w8 ? 16'h00FF : 16'hFFFF;
        gap = (last_rd && (we || cs != last_cs)) ? last_gap : 0;
        exp_q.push_back(e);
        rd_pat = 16'h4000 + addr[15:0];
        req_valid = 1; req_cs = 3'(cs); req_write = we; req_addr = addr;
        req_wdata = wd; req_be = be;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (!req_ready && (mem_cs_n != 8'hFF) && mem_addr != e.addr)
                chk(0, "R9 address value", mem_addr, e.addr);
        end while (!req_ready && lat < 1000);
        want = 2 * e.ag + e.su + e.st + e.hd + 1 + gap;
        chk(lat == want, {"R7/R8 latency ", tag}, lat, want);
        if (!we) begin
            exp_rd = (rd_pat + 16'(e.st - 1)) & e.mask;
            chk(req_rdata == exp_rd, {"R7/R9 read data ", tag}, req_rdata, exp_rd);
        end
        last_rd = !we; last_cs = cs; last_gap = int'(w[11:8]);
        req_valid = 0;
        @(negedge clk);
        chk(req_ready == 0, "R7 ready one cycle", req_ready, 0);
    endtask

    initial begin
        cfgw[0] = mk(0, 0, 0, 0, 1, 0, 0, 0, 0);
        cfgw[1] = mk(3, 1, 2, 0, 1, 1, 0, 1, 3);
        cfgw[2] = mk(1, 2, 1, 1, 1, 0, 3, 0, 5);
        cfgw[3] = mk(1, 1, 3, 0, 2, 0, 0, 1, 0);
        cfgw[4] = mk(0, 2, 0, 0, 1, 0, 4, 1, 10);
        cfgw[5] = mk(2, 0, 1, 0, 2, 0, 2, 1, 127);
        cfgw[6] = mk(1, 1, 1, 1, 1, 1, 0, 0, 0);
        cfgw[7] = mk(3, 3, 3, 0, 1, 1, 15, 1, 1);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_cs_n == 8'hFF, "R1 cs high", mem_cs_n, 8'hFF);
        chk(mem_rd_n && mem_wr_n == 2'b11, "R1 strobes high", {mem_rd_n, mem_wr_n}, 7);
        chk(!req_ready && !mem_dq_oe, "R1 ready/oe low", {req_ready, mem_dq_oe}, 0);
        chk(mem_addr == 0, "R1 address zero", mem_addr, 0);
        rst_n = 1;
        @(negedge clk);
        do_acc(0, 1, 24'h000010, 16'hA5C3, 2'b11, "cs0 wr");
        do_acc(0, 0, 24'h000010, 16'h0, 2'b11, "cs0 rd");
        do_acc(1, 1, 24'h000104, 16'h1234, 2'b01, "cs1 dual lo");
        do_acc(1, 1, 24'h000106, 16'h5678, 2'b10, "cs1 dual hi");
        do_acc(1, 1, 24'h000108, 16'h9ABC, 2'b11, "cs1 dual both");
        do_acc(2, 1, 24'h000200, 16'h0F0F, 2'b01, "cs2 single be ignored");
        do_acc(2, 0, 24'h000202, 16'h0, 2'b11, "cs2 early rd");
        do_acc(2, 0, 24'h000204, 16'h0, 2'b11, "cs2 rd after rd same cs");
        do_acc(2, 1, 24'h000206, 16'hBEEF, 2'b11, "cs2 wr after rd gap");
        do_acc(2, 0, 24'h000208, 16'h0, 2'b11, "cs2 rd");
        do_acc(1, 0, 24'h00010A, 16'h0, 2'b11, "cs1 rd other cs gap");
        do_acc(3, 0, 24'h000301, 16'h0, 2'b11, "cs3 8bit rd");
        do_acc(3, 1, 24'h000303, 16'hCC5A, 2'b10, "cs3 8bit wr");
        do_acc(4, 0, 24'h000400, 16'h0, 2'b11, "cs4 rd");
        do_acc(4, 0, 24'h000402, 16'h0, 2'b11, "cs4 rd same cs");
        do_acc(0, 0, 24'h000012, 16'h0, 2'b11, "cs0 rd after cs4 gap");
        do_acc(5, 0, 24'h000501, 16'h0, 2'b11, "cs5 long strobe rd");
        do_acc(5, 1, 24'h000502, 16'h7711, 2'b11, "cs5 wr after rd");
        do_acc(7, 1, 24'h000700, 16'h2468, 2'b10, "cs7 wr");
        do_acc(7, 0, 24'h000702, 16'h0, 2'b11, "cs7 rd");
        do_acc(6, 1, 24'h000600, 16'h1357, 2'b01, "cs6 wr after cs7 rd");
        do_acc(6, 0, 24'h000602, 16'h0, 2'b11, "cs6 early rd");
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all accesses seen", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule